// File: doc/BRIEF.md
# Parallel NOR Flash Erase Sequencer

This block drives a parallel NOR flash through a complete erase. On a request it issues six single-cycle writes (a fixed unlock preamble followed by an erase-type byte) and then polls the device status word until the erase finishes, fails, or runs out of polling attempts. It acts as a bus master on a simple synchronous port: a write is one cycle with the write strobe high; a read is one cycle with the read strobe high, and the device presents the status byte from the next clock edge on.

The caller picks an erase granularity and one of two command families. Each family has its own capabilities. A granularity the family cannot perform falls back to a sector erase. The families also differ in how status is judged: one treats the exceeded-timing-limit status bit as a possible fault, while the other ignores that bit. A programmable poll budget protects against a device that never reports completion.

Top module: `flash_erase_ctrl`

## Requirements
- R1: In the cycle after a request is accepted in idle, the block drives the first of six consecutive one-cycle writes. The address/data pairs in order are 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA and 0x2AA/0x55, followed by the erase write. busy is high from that first write until completion.
- R2: The erase write carries 0x30 to the request address for a sector erase, 0x50 to the request address for a block erase, and 0x10 to address 0x555 for a chip erase.
- R3: Mode encoding on req_mode is 0 = sector, 1 = chip, 2 = block. Code 3 is treated as sector, which is the default.
- R4: Family encoding on req_alg is 0 = AMD-style and 1 = AT49-style. Chip erase runs under both families. Block erase runs only under AT49-style; under AMD-style a block request performs a sector erase.
- R5: After the erase write, the block issues one-cycle status reads at the request address, with one idle cycle between reads. It evaluates rd_data in the cycle after that idle cycle. If bit 7 is 1, done pulses for one cycle with error low, busy drops, and the block returns to idle.
- R6: Under AMD-style, if bit 7 is 0 and bit 5 is 1, the block issues exactly one more read. If that read shows bit 7 = 0, done and error pulse together. If it shows bit 7 = 1, the erase succeeds.
- R7: Under AT49-style, bit 5 of the status has no effect; polling continues until bit 7 or the budget ends it.
- R8: poll_limit, sampled at acceptance, bounds the status reads. When the N-th read with bit 7 = 0 is evaluated and N >= poll_limit, done and error pulse together. A limit of 0 behaves as 1.
- R9: A request seen while busy is ignored. The two strobes are never high together. Address and write data are zero in every cycle without a strobe.
- R10: During and directly after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request, taken when idle |
| req_addr | input | AW | Target address of the erase |
| req_mode | input | 2 | Erase granularity code |
| req_alg | input | 1 | Command family select |
| poll_limit | input | TW | Maximum number of status reads |
| rd_data | input | DW | Status byte from the flash |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |

## Verification
The bench builds the block with a 16-bit address and an 8-bit poll budget. The narrow address keeps expected bus words short and leaves the unlock addresses clearly distinct from the target addresses. The small budget lets single-digit limits, including 0, reach the timeout path within a few reads. A scripted device model, with a programmable cycle for bit 7 and for bit 5, brings the re-read success and failure paths and the ignored-bit-5 path within reach of short runs.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [1:0] {
    EM_SECTOR = 2'd0,
    EM_CHIP   = 2'd1,
    EM_BLOCK  = 2'd2,
    EM_RSVD   = 2'd3
  } erase_mode_e;

  typedef enum logic {
    ALG_AMD  = 1'b0,
    ALG_AT49 = 1'b1
  } erase_alg_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CMD    = 2'd1,
    ST_RDHOLD = 2'd2,
    ST_EVAL   = 2'd3
  } fe_state_e;

  localparam int SEQ_LEN      = 6;
  localparam int STAT_DONE    = 7;
  localparam int STAT_TMO     = 5;
  localparam logic [11:0] UNLK_HI = 12'h555;
  localparam logic [11:0] UNLK_LO = 12'h2AA;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_BLOCK  = 8'h50;

  // Preamble byte for command slot idx (0..4)
  function automatic logic [7:0] pre_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    pre_byte = 8'hAA;
      3'd1:    pre_byte = 8'h55;
      3'd2:    pre_byte = 8'h80;
      3'd3:    pre_byte = 8'hAA;
      default: pre_byte = 8'h55;
    endcase
  endfunction

  // Whether preamble slot idx addresses the high unlock location
  function automatic logic pre_hi(input logic [2:0] idx);
    pre_hi = (idx == 3'd0) || (idx == 3'd2) || (idx == 3'd3);
  endfunction

endpackage

// File: rtl/fe_mode_resolve.sv
module fe_mode_resolve
  import fe_pkg::*;
(
  input  logic [1:0] mode_in,
  input  logic       alg_in,
  output logic [1:0] mode_eff,
  output logic [7:0] final_code,
  output logic       final_at_unlock,
  output logic       chk_tmo_bit
);
  erase_mode_e m_req;
  erase_mode_e m_eff;
  erase_alg_e  alg;

  always_comb begin
    m_req = erase_mode_e'(mode_in);
    alg   = erase_alg_e'(alg_in);
    case (m_req)
      EM_CHIP:  m_eff = EM_CHIP;
      EM_BLOCK: m_eff = (alg == ALG_AT49) ? EM_BLOCK : EM_SECTOR;
      default:  m_eff = EM_SECTOR;
    endcase
    case (m_eff)
      EM_CHIP:  final_code = CODE_CHIP;
      EM_BLOCK: final_code = CODE_BLOCK;
      default:  final_code = CODE_SECTOR;
    endcase
    final_at_unlock = (m_eff == EM_CHIP);
    chk_tmo_bit     = (alg == ALG_AMD);
    mode_eff        = m_eff;
  end

  // R4: the AMD-style family never ends up with a block erase
  always_comb begin
    if (alg_in == 1'b0)
      p_amd_no_block_r4: assert (mode_eff != EM_BLOCK);
  end

endmodule

// File: rtl/fe_cmd_seq.sv
module fe_cmd_seq
  import fe_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 8
) (
  input  logic [2:0]    idx,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    final_code,
  input  logic          final_at_unlock,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  localparam logic [2:0] LAST_IDX = 3'(SEQ_LEN - 1);
  localparam logic [AW-1:0] A_HI = AW'(UNLK_HI);
  localparam logic [AW-1:0] A_LO = AW'(UNLK_LO);

  always_comb begin
    if (idx == LAST_IDX) begin
      cmd_addr = final_at_unlock ? A_HI : tgt_addr;
      cmd_data = DW'(final_code);
    end else begin
      cmd_addr = pre_hi(idx) ? A_HI : A_LO;
      cmd_data = DW'(pre_byte(idx));
    end
  end

endmodule

// File: rtl/fe_poll_ctr.sv
module fe_poll_ctr #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic [TW-1:0] limit_in,
  input  logic          step,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      limit_q <= '0;
    end else if (clear) begin
      cnt     <= '0;
      limit_q <= limit_in;
    end else if (step && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // True when the read being evaluated now uses up the budget
  assign expired = ({1'b0, cnt} + 1'b1) >= {1'b0, limit_q};

  // R8: an evaluated read advances the count by one until saturation
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && (cnt != '1)) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fe_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_mode,
  input  logic          req_alg,
  input  logic [TW-1:0] poll_limit,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  output logic          busy,
  output logic          done,
  output logic          error
);
  localparam logic [2:0] LAST_IDX = 3'(SEQ_LEN - 1);

  fe_state_e     state;
  logic [2:0]    step;
  logic [AW-1:0] tgt_q;
  logic [7:0]    code_q;
  logic          at_unlock_q;
  logic          chk_tmo_q;
  logic          reread_q;

  logic [1:0]    mode_eff;
  logic [7:0]    res_code;
  logic          res_at_unlock;
  logic          res_chk_tmo;
  logic [2:0]    seq_idx;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_data;
  logic          accept;
  logic          eval_step;
  logic          budget_out;

  fe_mode_resolve u_resolve (
    .mode_in         (req_mode),
    .alg_in          (req_alg),
    .mode_eff        (mode_eff),
    .final_code      (res_code),
    .final_at_unlock (res_at_unlock),
    .chk_tmo_bit     (res_chk_tmo)
  );

  assign seq_idx = (state == ST_IDLE) ? 3'd0 : step + 3'd1;

  fe_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .idx             (seq_idx),
    .tgt_addr        (tgt_q),
    .final_code      (code_q),
    .final_at_unlock (at_unlock_q),
    .cmd_addr        (seq_addr),
    .cmd_data        (seq_data)
  );

  assign accept    = (state == ST_IDLE) && req_valid;
  assign eval_step = (state == ST_EVAL);

  fe_poll_ctr #(.TW(TW)) u_budget (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .limit_in (poll_limit),
    .step     (eval_step),
    .expired  (budget_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      step        <= '0;
      tgt_q       <= '0;
      code_q      <= '0;
      at_unlock_q <= 1'b0;
      chk_tmo_q   <= 1'b0;
      reread_q    <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_we      <= 1'b0;
      bus_re      <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      error       <= 1'b0;
    end else begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            tgt_q       <= req_addr;
            code_q      <= res_code;
            at_unlock_q <= res_at_unlock;
            chk_tmo_q   <= res_chk_tmo;
            reread_q    <= 1'b0;
            step        <= 3'd0;
            busy        <= 1'b1;
            bus_we      <= 1'b1;
            bus_addr    <= seq_addr;
            bus_wdata   <= seq_data;
            state       <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (step == LAST_IDX) begin
            bus_re   <= 1'b1;
            bus_addr <= tgt_q;
            state    <= ST_RDHOLD;
          end else begin
            step      <= step + 3'd1;
            bus_we    <= 1'b1;
            bus_addr  <= seq_addr;
            bus_wdata <= seq_data;
          end
        end
        ST_RDHOLD: state <= ST_EVAL;
        default: begin
          if (rd_data[STAT_DONE]) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (reread_q) begin
            done  <= 1'b1;
            error <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else if (chk_tmo_q && rd_data[STAT_TMO]) begin
            reread_q <= 1'b1;
            bus_re   <= 1'b1;
            bus_addr <= tgt_q;
            state    <= ST_RDHOLD;
          end else if (budget_out) begin
            done  <= 1'b1;
            error <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            bus_re   <= 1'b1;
            bus_addr <= tgt_q;
            state    <= ST_RDHOLD;
          end
        end
      endcase
    end
  end

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && !bus_re) |-> (bus_addr == '0 && bus_wdata == '0));

  p_first_write_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (bus_we && bus_addr == AW'(UNLK_HI) && bus_wdata == DW'(8'hAA)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_read_single_r5: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_re);

  p_error_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

endmodule

// File: tb/flash_erase_ctrl_bench.sv
module flash_erase_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int TW = 8;
  localparam int VW = AW + DW + 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_mode = '0;
  logic          req_alg = 1'b0;
  logic [TW-1:0] poll_limit = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we, bus_re, busy, done, error;

  int n_checks = 0;
  int n_fail   = 0;
  int ready_at = -1;
  int dq5_at   = -1;
  int rdcnt    = 0;
  int cyc      = 0;

  always #5 clk = ~clk;

  flash_erase_ctrl #(.AW(AW), .DW(DW), .TW(TW)) u_flash_erase_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_mode(req_mode), .req_alg(req_alg), .poll_limit(poll_limit),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .busy(busy), .done(done), .error(error)
  );

  function automatic logic [7:0] stat(input int i);
    logic [7:0] s;
    s = 8'h04;
    if (ready_at >= 0 && i >= ready_at) s[7] = 1'b1;
    if (dq5_at >= 0 && i >= dq5_at) s[5] = 1'b1;
    return s;
  endfunction

  // Scripted flash: status appears the edge after a read strobe
  always @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rdcnt   <= 0;
    end else if (req_valid && !busy) begin
      rdcnt <= 0;
    end else if (bus_re) begin
      rd_data <= stat(rdcnt);
      rdcnt   <= rdcnt + 1;
    end
  end

  function automatic logic [VW-1:0] vec(input logic we, input logic re,
      input int a, input int d, input logic b, input logic dn, input logic er);
    return {we, re, AW'(a), DW'(d), b, dn, er};
  endfunction

  task automatic cmp(input logic [VW-1:0] e, input string tag);
    logic [VW-1:0] a;
    a = {bus_we, bus_re, bus_addr, bus_wdata, busy, done, error};
    n_checks++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, a, e);
    end
  endtask

  task automatic run(input string tag, input int addr, input int mode,
      input int alg, input int limit, input int rdy, input int d5, input bit poke);
    logic [VW-1:0] q[$];
    int eff, d6, a6, i, lim;
    bit rr;
    logic [7:0] s;
    eff = mode;
    if (mode == 3) eff = 0;
    if (mode == 2 && alg == 0) eff = 0;
    d6 = (eff == 1) ? 'h10 : (eff == 2) ? 'h50 : 'h30;
    a6 = (eff == 1) ? 'h555 : addr;
    lim = (limit < 1) ? 1 : limit;
    q.push_back(vec(1, 0, 'h555, 'hAA, 1, 0, 0));
    q.push_back(vec(1, 0, 'h2AA, 'h55, 1, 0, 0));
    q.push_back(vec(1, 0, 'h555, 'h80, 1, 0, 0));
    q.push_back(vec(1, 0, 'h555, 'hAA, 1, 0, 0));
    q.push_back(vec(1, 0, 'h2AA, 'h55, 1, 0, 0));
    q.push_back(vec(1, 0, a6, d6, 1, 0, 0));
    q.push_back(vec(0, 1, addr, 0, 1, 0, 0));
    q.push_back(vec(0, 0, 0, 0, 1, 0, 0));
    ready_at = rdy;
    dq5_at   = d5;
    i = 0;
    rr = 0;
    forever begin
      s = stat(i);
      i++;
      if (s[7]) begin q.push_back(vec(0, 0, 0, 0, 0, 1, 0)); break; end
      if (rr) begin q.push_back(vec(0, 0, 0, 0, 0, 1, 1)); break; end
      if (alg == 0 && s[5]) rr = 1;
      else if (i >= lim) begin q.push_back(vec(0, 0, 0, 0, 0, 1, 1)); break; end
      q.push_back(vec(0, 1, addr, 0, 1, 0, 0));
      q.push_back(vec(0, 0, 0, 0, 1, 0, 0));
    end
    q.push_back(vec(0, 0, 0, 0, 0, 0, 0));
    q.push_back(vec(0, 0, 0, 0, 0, 0, 0));
    req_addr   = AW'(addr);
    req_mode   = 2'(mode);
    req_alg    = alg[0];
    poll_limit = TW'(limit);
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < q.size(); k++) begin
      cmp(q[k], tag);
      if (poke && k == 3) begin
        req_valid = 1'b1;
        req_addr  = AW'('h1234);
        req_mode  = 2'd1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      cmp('0, "R10 in reset");
    end
    rst = 1'b0;
    @(negedge clk);
    cmp('0, "R10 after reset");
    run("R1 R2 R5 amd sector",     'h4A00, 0, 0, 10, 2, -1, 0);
    run("R2 R4 amd chip",          'h8800, 1, 0, 10, 0, -1, 0);
    run("R2 R4 at49 block",        'h3100, 2, 1, 10, 1, -1, 0);
    run("R2 R4 at49 chip",         'h0F00, 1, 1, 10, 0, -1, 0);
    run("R4 amd block->sector",    'h7700, 2, 0, 10, 1, -1, 0);
    run("R3 reserved->sector",     'h2200, 3, 1, 10, 0, -1, 0);
    run("R3 reserved amd",         'h2300, 3, 0, 10, 1, -1, 0);
    run("R6 reread fails",         'h5500, 0, 0, 10, -1, 1, 0);
    run("R6 reread succeeds",      'h5600, 0, 0, 10, 2, 1, 0);
    run("R7 at49 ignores bit5",    'h6600, 0, 1, 10, 3, 0, 0);
    run("R8 budget of 3",          'h1100, 0, 1, 3, -1, -1, 0);
    run("R8 budget of 0",          'h1200, 2, 1, 0, -1, -1, 0);
    run("R8 budget edge ok",       'h1300, 0, 0, 3, 2, -1, 0);
    run("R9 request while busy",   'h9900, 0, 0, 10, 1, -1, 1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule